// File: doc/BRIEF.md
# Interrupt Register Unit

This block gathers four event pulses from neighbouring logic: data available, status valid, locality change and command ready. It latches each one into a sticky status bit and exposes enable, status, vector and capability registers on a simple 32-bit register write/read port. Software clears a status bit by writing a one to it. A global enable bit gates the single interrupt output. Two enable bits choose how that output signals: as a high level, as a low level, as a one-cycle high pulse, or as a one-cycle low pulse.

Reads are combinational from the current address. Writes take effect at the clock edge and honour per-byte strobes. The capability word is a read-only parameter. It advertises which sources and which signalling modes the unit supports.

Top module: `irq_unit`

## Requirements
- R1: After a synchronous active-low reset, the enable, status and vector registers read zero. In the default level-high mode, the output is low.
- R2: Register offsets are: enable 0x08, vector 0x0C, status 0x10, capability 0x14. The capability offset returns the CAPS parameter, and writes to it are ignored. Any other offset reads zero.
- R3: Only enable bits 31, 7, 4, 3, 2, 1 and 0 are writable, and the other bits read zero. Each byte lane is written only when its strobe bit is set (strobe bit n covers data bits 8n+7..8n).
- R4: An event pulse sets its status bit even when that source's enable bit is clear. The mapping is: data available to bit 0, status valid to bit 1, locality change to bit 2, command ready to bit 7.
- R5: A write to status clears each bit written as one in a strobed lane and leaves the others unchanged. An event arriving in the same cycle as a clear of its bit wins, so the bit stays set.
- R6: A vector write with strobe bit 0 set stores data bits 7..0, which read back in bits 7..0 with zeros above. A vector write without strobe bit 0 changes nothing.
- R7: The request is active only when enable bit 31 is set and some bit among 0, 1, 2 and 7 is set in both status and enable.
- R8: Sense code 00 (enable bits 4..3) drives the output equal to the request.
- R9: Sense code 01 drives the output as the inverse of the request.
- R10: Sense code 10 drives the output high only in the first cycle of each new request, and low otherwise.
- R11: Sense code 11 drives the output low only in the first cycle of each new request, and high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_wstrb | input | 4 | Byte lane strobes |
| bus_rdata | output | 32 | Read data for bus_addr |
| ev_data_avail | input | 1 | Data-available event pulse |
| ev_sts_valid | input | 1 | Status-valid event pulse |
| ev_loc_change | input | 1 | Locality-change event pulse |
| ev_cmd_ready | input | 1 | Command-ready event pulse |
| irq_out | output | 1 | Interrupt output in the selected sense |

## Verification
Two things can happen in the same cycle: a write-one-to-clear of a status bit and a fresh event on that same bit. The bench provokes this directly by pulsing an event in the cycle of its clear, and again at random throughout a long mixed run. The correct outcome is that the bit stays set and the request stays active. A second collision comes from rewriting the sense code while a request is already pending. The behavioural model, compared every cycle, judges whether the output then pulses or holds as the new code dictates.

// File: rtl/irq_unit_pkg.sv
// Shared constants for the interrupt register unit: offsets, bit positions,
// writable masks and the output sense encoding.
package irq_unit_pkg;
    localparam int REG_W = 32;
    localparam int VEC_W = 8;

    localparam logic [7:0] OFS_ENABLE = 8'h08;
    localparam logic [7:0] OFS_VECTOR = 8'h0C;
    localparam logic [7:0] OFS_STATUS = 8'h10;
    localparam logic [7:0] OFS_CAPS   = 8'h14;

    localparam int BIT_DAV  = 0;
    localparam int BIT_STV  = 1;
    localparam int BIT_LOC  = 2;
    localparam int BIT_CRDY = 7;
    localparam int BIT_SNS  = 3;
    localparam int BIT_GIE  = 31;

    localparam logic [REG_W-1:0] SRC_MASK    = 32'h0000_0087;
    localparam logic [REG_W-1:0] ENABLE_MASK = 32'h8000_009F;

    typedef enum logic [1:0] {
        SENSE_LVL_HI = 2'b00,
        SENSE_LVL_LO = 2'b01,
        SENSE_RISE   = 2'b10,
        SENSE_FALL   = 2'b11
    } sense_e;
endpackage

// File: rtl/irq_reg_file.sv
// Register file for the interrupt unit: enable, sticky status (write-one-to-clear),
// vector byte and read-only capability word.
// Assumes reads are combinational on addr and writes apply at the clock edge.
module irq_reg_file
    import irq_unit_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [REG_W-1:0] CAPS = 32'h0000_01FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic [REG_W/8-1:0] wstrb,
    input  logic [REG_W-1:0]  ev_vec,
    output logic [REG_W-1:0]  enable_q,
    output logic [REG_W-1:0]  status_q,
    output logic [VEC_W-1:0]  vector_q,
    output logic [REG_W-1:0]  rdata
);
    localparam int NBYTES = REG_W / 8;

    logic [REG_W-1:0] lane_mask;
    logic [REG_W-1:0] clr_mask;
    logic             hit_en, hit_st, hit_vec;

    // Expand byte strobes into a bit mask.
    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        assign lane_mask[8*b +: 8] = {8{wstrb[b]}};
    end

    assign hit_en  = wr_en && (addr == ADDR_W'(OFS_ENABLE));
    assign hit_st  = wr_en && (addr == ADDR_W'(OFS_STATUS));
    assign hit_vec = wr_en && (addr == ADDR_W'(OFS_VECTOR)) && wstrb[0];
    assign clr_mask = hit_st ? (wdata & lane_mask) : '0;

    // Enable register: strobed, masked to writable bits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            enable_q <= '0;
        else if (hit_en)
            enable_q <= (enable_q & ~lane_mask) | (wdata & lane_mask & ENABLE_MASK);
    end

    // Status register: events set, ones written clear, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)
            status_q <= '0;
        else
            status_q <= ((status_q & ~clr_mask) | ev_vec) & SRC_MASK;
    end

    // Vector register: low byte only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            vector_q <= '0;
        else if (hit_vec)
            vector_q <= wdata[VEC_W-1:0];
    end

    // Read multiplexer.
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(OFS_ENABLE))      rdata = enable_q;
        else if (addr == ADDR_W'(OFS_VECTOR)) rdata = {{(REG_W-VEC_W){1'b0}}, vector_q};
        else if (addr == ADDR_W'(OFS_STATUS)) rdata = status_q;
        else if (addr == ADDR_W'(OFS_CAPS))   rdata = CAPS;
    end

    a_r4_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ev_vec & SRC_MASK)) |=> ((status_q & $past(ev_vec & SRC_MASK)) == $past(ev_vec & SRC_MASK)));
    a_r5_clear_one: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_st && wstrb[0] && wdata[BIT_DAV] && !ev_vec[BIT_DAV]) |=> !status_q[BIT_DAV]);
    a_r5_keep_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q[BIT_CRDY] && !(hit_st && wstrb[0] && wdata[BIT_CRDY])) |=> status_q[BIT_CRDY]);
    a_r6_vector_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_vec |=> $stable(vector_q));
    a_r3_enable_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_en |=> $stable(enable_q));
endmodule

// File: rtl/irq_sense.sv
// Output shaping: turns the combined request into level or one-cycle pulse
// signalling according to the sense code. Assumes request comes from registers.
module irq_sense
    import irq_unit_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   request,
    input  sense_e mode,
    output logic   irq
);
    logic req_d;
    logic fresh;

    // Remember the previous request for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) req_d <= 1'b0;
        else        req_d <= request;
    end

    assign fresh = request && !req_d;

    // Select the output form.
    always_comb begin
        unique case (mode)
            SENSE_LVL_HI: irq = request;
            SENSE_LVL_LO: irq = !request;
            SENSE_RISE:   irq = fresh;
            SENSE_FALL:   irq = !fresh;
            default:      irq = request;
        endcase
    end

    a_r10_single_high: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SENSE_RISE && irq && $stable(mode)) |=> !(irq && mode == SENSE_RISE));
    a_r11_single_low: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SENSE_FALL && !irq) |=> (irq || mode != SENSE_FALL));
    a_r8_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SENSE_LVL_HI && !request) |-> !irq);
endmodule

// File: rtl/irq_unit.sv
// Top of the interrupt register unit. Maps event pulses onto status bit
// positions, forms the gated request and drives the shaped output.
// Assumes event inputs are single-cycle pulses synchronous to clk.
module irq_unit
    import irq_unit_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [31:0] CAPS = 32'h0000_01FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic [3:0]        bus_wstrb,
    output logic [31:0]       bus_rdata,
    input  logic              ev_data_avail,
    input  logic              ev_sts_valid,
    input  logic              ev_loc_change,
    input  logic              ev_cmd_ready,
    output logic              irq_out
);
    logic [REG_W-1:0] ev_vec;
    logic [REG_W-1:0] enable_q, status_q;
    logic [VEC_W-1:0] vector_q;
    logic             request;
    sense_e           mode;

    // Place each event on its status bit.
    always_comb begin
        ev_vec           = '0;
        ev_vec[BIT_DAV]  = ev_data_avail;
        ev_vec[BIT_STV]  = ev_sts_valid;
        ev_vec[BIT_LOC]  = ev_loc_change;
        ev_vec[BIT_CRDY] = ev_cmd_ready;
    end

    irq_reg_file #(.ADDR_W(ADDR_W), .CAPS(CAPS)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .wstrb    (bus_wstrb),
        .ev_vec   (ev_vec),
        .enable_q (enable_q),
        .status_q (status_q),
        .vector_q (vector_q),
        .rdata    (bus_rdata)
    );

    // Gated request from enabled, latched sources.
    assign request = enable_q[BIT_GIE] && (|(status_q & enable_q & SRC_MASK));
    assign mode    = sense_e'(enable_q[BIT_SNS +: 2]);

    irq_sense u_sense (
        .clk     (clk),
        .rst_n   (rst_n),
        .request (request),
        .mode    (mode),
        .irq     (irq_out)
    );

    a_r7_gie_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable_q[BIT_GIE] && mode == SENSE_LVL_HI) |-> !irq_out);
    a_r1_vector_zero: assert property (@(posedge clk)
        !rst_n |=> (vector_q == '0 && status_q == '0));
endmodule

// File: tb/irq_unit_test.sv
`timescale 1ns/100ps
module irq_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_wstrb = '0;
    logic [31:0] bus_rdata;
    logic        ev_da = 1'b0, ev_sv = 1'b0, ev_lc = 1'b0, ev_cr = 1'b0;
    logic        irq_out;

    localparam logic [31:0] CAPS_VAL = 32'h0000_01FF;

    int checks = 0;
    int errors = 0;
    bit chk_on = 1'b0;
    bit done = 1'b0;

    // model state
    logic [31:0] m_en = '0, m_st = '0;
    logic [7:0]  m_vec = '0;
    bit          m_pd = 1'b0;

    always #2.5 clk = ~clk;

    irq_unit uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_wstrb(bus_wstrb), .bus_rdata(bus_rdata),
        .ev_data_avail(ev_da), .ev_sts_valid(ev_sv), .ev_loc_change(ev_lc),
        .ev_cmd_ready(ev_cr), .irq_out(irq_out)
    );

    function automatic bit m_req();
        return m_en[31] && ((m_st & m_en & 32'h87) != 0);
    endfunction

    function automatic bit m_irq();
        bit r = m_req();
        case (m_en[4:3])
            2'b00: return r;
            2'b01: return !r;
            2'b10: return r && !m_pd;
            default: return !(r && !m_pd);
        endcase
    endfunction

    function automatic logic [31:0] m_rd(input logic [7:0] a);
        case (a)
            8'h08: return m_en;
            8'h0C: return {24'h0, m_vec};
            8'h10: return m_st;
            8'h14: return CAPS_VAL;
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural model update at each edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_en <= '0; m_st <= '0; m_vec <= '0; m_pd <= 1'b0;
            chk_on <= 1'b1;
        end else begin
            logic [31:0] lm, nst, clr;
            lm = '0;
            for (int b = 0; b < 4; b++) if (bus_wstrb[b]) lm[8*b +: 8] = 8'hFF;
            m_pd <= m_req();
            clr = (bus_wr && bus_addr == 8'h10) ? (bus_wdata & lm) : 32'h0;
            nst = m_st & ~clr;
            if (ev_da) nst[0] = 1'b1;
            if (ev_sv) nst[1] = 1'b1;
            if (ev_lc) nst[2] = 1'b1;
            if (ev_cr) nst[7] = 1'b1;
            m_st <= nst & 32'h87;
            if (bus_wr && bus_addr == 8'h08)
                m_en <= (m_en & ~lm) | (bus_wdata & lm & 32'h8000_009F);
            if (bus_wr && bus_addr == 8'h0C && bus_wstrb[0])
                m_vec <= bus_wdata[7:0];
        end
    end

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (chk_on && !done) begin
            string rt, it;
            case (bus_addr)
                8'h08: rt = "R3";
                8'h0C: rt = "R6";
                8'h10: rt = "R5";
                default: rt = "R2";
            endcase
            case (m_en[4:3])
                2'b00: it = "R8";
                2'b01: it = "R9";
                2'b10: it = "R10";
                default: it = "R11";
            endcase
            if (!rst_n) begin rt = "R1"; it = "R1"; end
            check(rt, bus_rdata, m_rd(bus_addr));
            check(it, {31'h0, irq_out}, {31'h0, m_irq()});
        end
    end

    task automatic step();
        @(posedge clk); #1;
        bus_wr = 1'b0; {ev_da, ev_sv, ev_lc, ev_cr} = 4'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_wstrb = s;
        step();
    endtask

    task automatic rd(input logic [7:0] a);
        bus_addr = a; step();
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset values
        rd(8'h08); rd(8'h10); rd(8'h0C);
        @(negedge clk); check("R1", {31'h0, irq_out}, 32'h0);
        #0.5;
        // R2: caps and unmapped, caps write ignored
        rd(8'h14); wr(8'h14, 32'hFFFF_FFFF, 4'hF); rd(8'h14); rd(8'h04); rd(8'h18);
        // R6: vector byte and lane
        wr(8'h0C, 32'hAABB_CC0B, 4'h1); rd(8'h0C);
        wr(8'h0C, 32'h0000_5500, 4'h2); rd(8'h0C);
        // R3: enables without global
        wr(8'h08, 32'h7FFF_FF87, 4'hF); rd(8'h08);
        // R4: events latch regardless of enable
        wr(8'h08, 32'h0, 4'hF);
        ev_da = 1; ev_cr = 1; step();
        rd(8'h10);
        @(negedge clk); check("R4", bus_rdata, 32'h81);
        #0.5;
        // R7: sources enabled, global off
        wr(8'h08, 32'h0000_0087, 4'hF);
        @(negedge clk); check("R7", {31'h0, irq_out}, 32'h0);
        #0.5;
        wr(8'h08, 32'h8000_0087, 4'hF); rd(8'h10);
        // R5: partial clear, then clear racing an event
        wr(8'h10, 32'h0000_0001, 4'hF); rd(8'h10);
        bus_wr = 1; bus_addr = 8'h10; bus_wdata = 32'h80; bus_wstrb = 4'h1; ev_cr = 1; step();
        @(negedge clk); check("R5", bus_rdata, 32'h80);
        #0.5;
        wr(8'h10, 32'h80, 4'h2); rd(8'h10);
        wr(8'h10, 32'h80, 4'h1); rd(8'h10);
        // R9, R10, R11 with fresh events
        for (int m = 1; m < 4; m++) begin
            wr(8'h08, 32'h8000_0087 | (m << 3), 4'hF);
            ev_sv = 1; step(); rd(8'h10); rd(8'h10);
            wr(8'h10, 32'hFF, 4'h1); rd(8'h10);
            ev_lc = 1; step(); rd(8'h08);
            wr(8'h10, 32'hFF, 4'h1);
        end
        // random mixed traffic
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] al [6];
            al = '{8'h08, 8'h0C, 8'h10, 8'h14, 8'h00, 8'h10};
            bus_addr = al[$urandom_range(0, 5)];
            bus_wr = ($urandom_range(0, 3) == 0);
            bus_wdata = $urandom();
            bus_wstrb = 4'($urandom());
            if (bus_wr && bus_addr == 8'h08 && $urandom_range(0, 1)) bus_wdata[31] = 1'b1;
            ev_da = ($urandom_range(0, 7) == 0);
            ev_sv = ($urandom_range(0, 7) == 0);
            ev_lc = ($urandom_range(0, 7) == 0);
            ev_cr = ($urandom_range(0, 7) == 0);
            step();
        end
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule